// File: doc/BRIEF.md
# Weighted Output Queue Scheduler

This block decides which of the output queues belonging to one port may send its next packet. Each queue holds a configured level from 0 to 9. Levels 0 to 8 act as weights. Each weight becomes a fixed 8-bit participation mask across eight scheduling rounds, and the set bits are spread so that one queue's packets do not arrive in clumps. Level 9 makes a queue strict-priority. A strict queue is served ahead of every weighted queue.

A consumer watches a one-hot grant with a valid flag. It takes a grant by raising `accept`. The grant stays fixed until it is taken, and scheduler state moves only on an accepted grant or on a cycle with nothing to grant. Levels are written one queue at a time through a small write port and may be changed while traffic flows. A checker that runs alongside reports setups that break the strict-run rules. The same logic also exposes the per-queue position flags that describe the port's layout.

Top module: `wosch_top`

## Requirements
- R1: After reset every level is 0, so no grant is made even when all queues are pending. The round counter starts at 0 and the round-robin start pointer at queue 0.
- R2: Level L (0..8) gives the mask 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. In round r (0..7), a weighted queue is eligible only if bit r of its mask is set, it is pending and it has not yet been served in this round. Two queues pending all the time at levels 1 and 8 are granted in the ratio 1:8.
- R3: Queues at level 9 that form the run starting at queue 0 are strict. If any strict queue is pending, the lowest-numbered pending strict queue gets the grant, and the round counter, the pointer and the served set stay unchanged.
- R4: Eligible weighted queues are granted round-robin, starting at the pointer. The pointer is cleared to queue 0 at reset and moves to one past each accepted weighted grant. The round advances and the served set clears when the accepted grant was the last eligible queue of the round, or on any cycle with no grant.
- R5: `grant` is one-hot when `grantValid` is 1 and zero otherwise. A valid grant holds its value until the cycle `accept` is 1. `accept` with no valid grant has no effect.
- R6: `cfgError` is 1 when an active queue has a level above 9, or when an active level-9 queue follows an active queue that is not level 9. The second case covers a strict run that does not start at queue 0 and a strict queue after the run has ended. A level above 9 uses mask 0xff, and a level-9 queue outside the run is scheduled as weighted with mask 0xff.
- R7: Bit i of `tailFlags` is 1 for i = numQueues-1. Bit i of `staticQueueFlags` is 1 for queues in the strict run. Bit i of `strictTailFlags` is 1 for the last queue of that run. `staticPortFlag` is 1 when any active queue is at level 9.
- R8: Queues with index ≥ `numQueues` are never granted and take no part in R6 or R7.
- R9: A level write takes effect in the cycle after `cfgWe`, including while grants are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Level write strobe |
| cfgQueue | input | 4 | Queue index written |
| cfgLevel | input | 4 | Level written (0..8 weight, 9 strict) |
| numQueues | input | 5 | Number of active queues for the port (0..16) |
| pending | input | 16 | Per-queue packet pending flags |
| accept | input | 1 | Consumer takes the current grant |
| grant | output | 16 | One-hot granted queue |
| grantValid | output | 1 | A grant is offered |
| cfgError | output | 1 | Illegal level setup detected |
| tailFlags | output | 16 | Last active queue of the port |
| strictTailFlags | output | 16 | Last queue of the strict run |
| staticPortFlag | output | 1 | Port has at least one level-9 queue |
| staticQueueFlags | output | 16 | Queue lies in the strict run |

## Verification
Two things can happen in one cycle: a level write, and a grant being accepted that advances the round. A write can also turn the queue now being offered or held into a strict queue or a zero-weight queue. The bench brings both about by issuing random level writes on cycles that also carry random pending and accept patterns. A behavioural model reads the write only for the next cycle, while the accepted grant keeps the type it had when it was offered. The grant, the flags and the error output are compared with that model on every cycle, so any mix-up in which update wins shows up as a grant mismatch a cycle or more later.

// File: rtl/wosch_pkg.sv
package wosch_pkg;

  localparam int LVL_W = 4;
  localparam int ROUND_BITS = 3;
  localparam logic [LVL_W-1:0] STRICT_LVL = 4'd9;

  // strobes from control to datapath
  typedef struct packed {
    logic lockLoad;
    logic commitW;
    logic roundStep;
  } schStrobe_t;

  function automatic logic [7:0] levelMask(input logic [LVL_W-1:0] lvl);
    logic [7:0] m;
    case (lvl)
      4'd0: m = 8'h00;
      4'd1: m = 8'h01;
      4'd2: m = 8'h11;
      4'd3: m = 8'h49;
      4'd4: m = 8'h55;
      4'd5: m = 8'h57;
      4'd6: m = 8'h77;
      4'd7: m = 8'h7f;
      default: m = 8'hff;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wosch_dp.sv
module wosch_dp
  import wosch_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int IDX_W = $clog2(NUM_Q),
  localparam int CNT_W = $clog2(NUM_Q + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgQueue,
  input  logic [LVL_W-1:0] cfgLevel,
  input  logic [CNT_W-1:0] numQueues,
  input  logic [NUM_Q-1:0] pending,
  input  logic             locked,
  input  schStrobe_t       strobe,
  output logic [NUM_Q-1:0] grant,
  output logic             grantValid,
  output logic             outStrict,
  output logic             lastInRound,
  output logic             cfgError,
  output logic [NUM_Q-1:0] tailFlags,
  output logic [NUM_Q-1:0] strictTailFlags,
  output logic             staticPortFlag,
  output logic [NUM_Q-1:0] staticQueueFlags
);

  logic [LVL_W-1:0]      levelQ [NUM_Q];
  logic [ROUND_BITS-1:0] roundQ;
  logic [IDX_W-1:0]      ptrQ;
  logic [NUM_Q-1:0]      servedQ;
  logic [NUM_Q-1:0]      heldGrantQ;
  logic                  heldStrictQ;

  logic [NUM_Q-1:0] activeV, strictV, badV, runV, startErrV, roundBitV;
  logic [7:0]       maskV [NUM_Q];

  // per-queue configuration decode
  for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_q
    assign activeV[gq]   = CNT_W'(gq) < numQueues;
    assign strictV[gq]   = activeV[gq] && (levelQ[gq] == STRICT_LVL);
    assign badV[gq]      = activeV[gq] && (levelQ[gq] > STRICT_LVL);
    assign maskV[gq]     = levelMask(levelQ[gq]);
    assign roundBitV[gq] = maskV[gq][roundQ];
    assign tailFlags[gq] = CNT_W'(gq + 1) == numQueues;
    if (gq == 0) begin : g_first
      assign runV[gq]      = strictV[gq];
      assign startErrV[gq] = 1'b0;
    end else begin : g_rest
      assign runV[gq]      = runV[gq-1] & strictV[gq];
      assign startErrV[gq] = strictV[gq] & ~strictV[gq-1];
    end
    if (gq == NUM_Q - 1) begin : g_lastq
      assign strictTailFlags[gq] = runV[gq];
    end else begin : g_midq
      assign strictTailFlags[gq] = runV[gq] & ~runV[gq+1];
    end
  end

  assign cfgError         = (|badV) | (|startErrV);
  assign staticPortFlag   = |strictV;
  assign staticQueueFlags = runV;

  // candidate selection
  logic [NUM_Q-1:0] eligV, strictPend, strictPick, rrPick, candGrant;
  logic             rrFound, candStrict;

  assign eligV      = pending & activeV & ~runV & roundBitV & ~servedQ;
  assign strictPend = pending & runV;
  assign strictPick = strictPend & (~strictPend + 1'b1);

  always_comb begin
    rrPick  = '0;
    rrFound = 1'b0;
    for (int k = 0; k < NUM_Q; k++) begin
      int idx;
      idx = (int'(ptrQ) + k) % NUM_Q;
      if (!rrFound && eligV[idx]) begin
        rrPick[idx] = 1'b1;
        rrFound     = 1'b1;
      end
    end
  end

  assign candStrict  = |strictPend;
  assign candGrant   = candStrict ? strictPick : rrPick;
  assign grant       = locked ? heldGrantQ : candGrant;
  assign grantValid  = locked | candStrict | rrFound;
  assign outStrict   = locked ? heldStrictQ : candStrict;
  assign lastInRound = (eligV & ~grant) == '0;

  logic [IDX_W-1:0] grantIdx;
  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_Q; i++)
      if (grant[i]) grantIdx = IDX_W'(i);
  end

  // state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_Q; i++) levelQ[i] <= '0;
    end else if (cfgWe) begin
      levelQ[cfgQueue] <= cfgLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roundQ      <= '0;
      ptrQ        <= '0;
      servedQ     <= '0;
      heldGrantQ  <= '0;
      heldStrictQ <= 1'b0;
    end else begin
      if (strobe.lockLoad) begin
        heldGrantQ  <= grant;
        heldStrictQ <= outStrict;
      end
      if (strobe.commitW) begin
        servedQ <= servedQ | grant;
        ptrQ    <= (grantIdx == IDX_W'(NUM_Q - 1)) ? '0 : grantIdx + 1'b1;
      end
      if (strobe.roundStep) begin
        roundQ  <= roundQ + 1'b1;
        servedQ <= '0;
      end
    end
  end

endmodule

// File: rtl/wosch_ctrl.sv
module wosch_ctrl
  import wosch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       grantValid,
  input  logic       outStrict,
  input  logic       lastInRound,
  output logic       locked,
  output schStrobe_t strobe
);

  logic lockedQ;

  always_comb begin
    strobe.lockLoad  = grantValid & ~accept & ~lockedQ;
    strobe.commitW   = grantValid & accept & ~outStrict;
    strobe.roundStep = ~grantValid | (grantValid & accept & ~outStrict & lastInRound);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lockedQ <= 1'b0;
    else if (grantValid & accept) lockedQ <= 1'b0;
    else if (strobe.lockLoad)     lockedQ <= 1'b1;
  end

  assign locked = lockedQ;

endmodule

// File: rtl/wosch_top.sv
module wosch_top
  import wosch_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int IDX_W = $clog2(NUM_Q),
  localparam int CNT_W = $clog2(NUM_Q + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgQueue,
  input  logic [LVL_W-1:0] cfgLevel,
  input  logic [CNT_W-1:0] numQueues,
  input  logic [NUM_Q-1:0] pending,
  input  logic             accept,
  output logic [NUM_Q-1:0] grant,
  output logic             grantValid,
  output logic             cfgError,
  output logic [NUM_Q-1:0] tailFlags,
  output logic [NUM_Q-1:0] strictTailFlags,
  output logic             staticPortFlag,
  output logic [NUM_Q-1:0] staticQueueFlags
);

  schStrobe_t strobe;
  logic       locked, outStrict, lastInRound;

  wosch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accept(accept), .grantValid(grantValid),
    .outStrict(outStrict), .lastInRound(lastInRound),
    .locked(locked), .strobe(strobe)
  );

  wosch_dp #(.NUM_Q(NUM_Q)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgQueue(cfgQueue),
    .cfgLevel(cfgLevel), .numQueues(numQueues), .pending(pending),
    .locked(locked), .strobe(strobe), .grant(grant), .grantValid(grantValid),
    .outStrict(outStrict), .lastInRound(lastInRound), .cfgError(cfgError),
    .tailFlags(tailFlags), .strictTailFlags(strictTailFlags),
    .staticPortFlag(staticPortFlag), .staticQueueFlags(staticQueueFlags)
  );

endmodule

// File: rtl/wosch_chk.sv
module wosch_chk #(
  parameter int NUM_Q = 16,
  localparam int IDX_W = $clog2(NUM_Q),
  localparam int CNT_W = $clog2(NUM_Q + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [IDX_W-1:0] cfgQueue,
  input logic [3:0]       cfgLevel,
  input logic [CNT_W-1:0] numQueues,
  input logic [NUM_Q-1:0] pending,
  input logic             accept,
  input logic [NUM_Q-1:0] grant,
  input logic             grantValid,
  input logic             cfgError,
  input logic [NUM_Q-1:0] tailFlags,
  input logic [NUM_Q-1:0] strictTailFlags,
  input logic             staticPortFlag,
  input logic [NUM_Q-1:0] staticQueueFlags
);

  // grant held over from the previous cycle
  logic heldR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldR <= 1'b0;
    else       heldR <= grantValid & ~accept;
  end

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $onehot(grant));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grant == '0);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !accept |=> grantValid && $stable(grant));

  a_r3_strict_first: assert property (@(posedge clk) disable iff (!rstN)
    !heldR && (|(pending & staticQueueFlags)) |-> grantValid && (|(grant & staticQueueFlags)));

  a_r6_bad_level: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && cfgLevel > 4'd9 && CNT_W'(cfgQueue) < numQueues |=> (!$stable(numQueues) || cfgError));

  a_r7_tail: assert property (@(posedge clk) disable iff (!rstN)
    numQueues != '0 |-> $onehot(tailFlags));

  a_r7_strict_tail: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strictTailFlags) && ((|staticQueueFlags) == $onehot(strictTailFlags)));

  a_r7_static_port: assert property (@(posedge clk) disable iff (!rstN)
    (|staticQueueFlags) |-> staticPortFlag);

  a_r8_inactive: assert property (@(posedge clk) disable iff (!rstN)
    !heldR && grantValid |-> ((32'(grant) >> numQueues) == 0));

endmodule

bind wosch_top wosch_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgQueue(cfgQueue),
  .cfgLevel(cfgLevel), .numQueues(numQueues), .pending(pending),
  .accept(accept), .grant(grant), .grantValid(grantValid),
  .cfgError(cfgError), .tailFlags(tailFlags),
  .strictTailFlags(strictTailFlags), .staticPortFlag(staticPortFlag),
  .staticQueueFlags(staticQueueFlags)
);

// File: tb/test_wosch_top.sv
`timescale 1ns/100ps
module test_wosch_top;
  localparam int NQ = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cfgWe, accept, grantValid, cfgError, staticPortFlag;
  logic [3:0] cfgQueue, cfgLevel;
  logic [4:0] numQueues;
  logic [NQ-1:0] pending, grant, tailFlags, strictTailFlags, staticQueueFlags;

  wosch_top i_wosch_top (.*);

  int checks = 0, fails = 0;
  int accMode = 1;
  logic [NQ-1:0] lastObs;
  int cnt [NQ];

  // behavioural model state
  int mLvl [NQ];
  int mRound, mPtr, mHeld;
  bit [NQ-1:0] mServed;
  bit mLocked, mHeldStrict;
  // model outputs
  int eG; bit eValid, eStrict, eLast, eErr, eSP;
  bit [NQ-1:0] eTail, eSTail, eSQ, eElig;

  function automatic int maskOf(int l);
    case (l)
      0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
      4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7f;
      default: return 'hff;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelEval();
    bit run; int nq; int sg; int rg;
    nq = int'(numQueues);
    run = 1; eErr = 0; eSP = 0; eSQ = '0; eSTail = '0; eTail = '0;
    for (int q = 0; q < NQ; q++) begin
      bit act; act = q < nq;
      if (act && mLvl[q] > 9) eErr = 1;
      if (act && mLvl[q] == 9) begin
        eSP = 1;
        if (q > 0 && mLvl[q-1] != 9) eErr = 1;
      end
      run = run && act && mLvl[q] == 9;
      eSQ[q] = run;
      if (q == nq - 1) eTail[q] = 1;
    end
    for (int q = 0; q < NQ; q++)
      if (eSQ[q] && (q == NQ - 1 || !eSQ[q+1])) eSTail[q] = 1;
    sg = -1;
    for (int q = NQ - 1; q >= 0; q--) if (eSQ[q] && pending[q]) sg = q;
    eElig = '0;
    for (int q = 0; q < nq; q++)
      if (!eSQ[q] && pending[q] && !mServed[q] && ((maskOf(mLvl[q]) >> mRound) & 1))
        eElig[q] = 1;
    rg = -1;
    for (int k = NQ - 1; k >= 0; k--) if (eElig[(mPtr + k) % NQ]) rg = (mPtr + k) % NQ;
    if (mLocked) begin eG = mHeld; eStrict = mHeldStrict; end
    else if (sg >= 0) begin eG = sg; eStrict = 1; end
    else begin eG = rg; eStrict = 0; end
    eValid = eG >= 0;
    eLast = eValid ? ((eElig & ~(NQ'(1) << eG)) == '0) : (eElig == '0);
  endtask

  task automatic modelUpdate();
    if (cfgWe) mLvl[cfgQueue] = int'(cfgLevel);
    if (eValid) begin
      if (accept) begin
        mLocked = 0;
        if (!eStrict) begin
          mServed[eG] = 1;
          mPtr = (eG + 1) % NQ;
          if (eLast) begin mRound = (mRound + 1) % 8; mServed = '0; end
        end
      end else if (!mLocked) begin
        mLocked = 1; mHeld = eG; mHeldStrict = eStrict;
      end
    end else begin
      mRound = (mRound + 1) % 8; mServed = '0;
    end
  endtask

  task automatic tick();
    modelEval();
    accept = (accMode == 1) || (accMode == 2 && ($urandom % 2 == 1));
    #1;
    chk("R3 R4 R5 R8 R9 grant", 32'(grant), eValid ? (32'(1) << eG) : 0);
    chk("R5 grantValid", 32'(grantValid), 32'(eValid));
    chk("R6 cfgError", 32'(cfgError), 32'(eErr));
    chk("R7 tailFlags", 32'(tailFlags), 32'(eTail));
    chk("R7 strictTailFlags", 32'(strictTailFlags), 32'(eSTail));
    chk("R7 staticQueueFlags", 32'(staticQueueFlags), 32'(eSQ));
    chk("R7 staticPortFlag", 32'(staticPortFlag), 32'(eSP));
    lastObs = grant;
    if (grantValid && accept)
      for (int q = 0; q < NQ; q++) if (grant[q]) cnt[q]++;
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic wrLvl(int q, int l);
    cfgWe = 1; cfgQueue = 4'(q); cfgLevel = 4'(l);
    tick();
    cfgWe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NQ-1:0] first;
    for (int q = 0; q < NQ; q++) mLvl[q] = 0;
    mRound = 0; mPtr = 0; mServed = '0; mLocked = 0; mHeld = 0; mHeldStrict = 0;
    rstN = 0; cfgWe = 0; cfgQueue = 0; cfgLevel = 0; numQueues = 5'd16;
    pending = '0; accept = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state, all pending but every level is 0
    pending = '1;
    tick();
    chk("R1 no grant after reset", 32'(lastObs), 0);
    tick();
    pending = '0;

    // R2: weights 1 and 8 give 1:8 service
    numQueues = 5'd2;
    wrLvl(0, 1); wrLvl(1, 8);
    pending = 16'h0003; accMode = 1;
    repeat (20) tick();
    for (int q = 0; q < NQ; q++) cnt[q] = 0;
    repeat (72) tick();
    chk("R2 level1 grants", 32'(cnt[0]), 8);
    chk("R2 level8 grants", 32'(cnt[1]), 64);
    pending = '0;

    // R3: strict run beats weighted queues
    numQueues = 5'd4;
    wrLvl(0, 9); wrLvl(1, 9); wrLvl(2, 8); wrLvl(3, 8);
    pending = 16'h000f;
    tick(); chk("R3 lowest strict", 32'(lastObs), 32'h1);
    tick(); chk("R3 lowest strict again", 32'(lastObs), 32'h1);
    pending = 16'h000e;
    tick(); chk("R3 second strict", 32'(lastObs), 32'h2);
    pending = 16'h000c;
    tick(); chk("R4 weighted after strict", 32'(lastObs & 16'h000c) != 0, 1);
    pending = '0;

    // R6/R7/R8: setup checks
    wrLvl(0, 8); tick(); chk("R6 strict not at queue 0", 32'(cfgError), 1);
    wrLvl(0, 9); wrLvl(1, 8); wrLvl(2, 9); tick();
    chk("R6 strict after run end", 32'(cfgError), 1);
    wrLvl(1, 9); wrLvl(2, 8); tick();
    chk("R6 legal strict run", 32'(cfgError), 0);
    chk("R7 staticQueueFlags", 32'(staticQueueFlags), 32'h3);
    chk("R7 strictTailFlags", 32'(strictTailFlags), 32'h2);
    chk("R7 tailFlags", 32'(tailFlags), 32'h8);
    wrLvl(3, 12); tick(); chk("R6 level above 9", 32'(cfgError), 1);
    wrLvl(3, 8); wrLvl(5, 12); tick();
    chk("R8 inactive bad level ignored", 32'(cfgError), 0);
    wrLvl(5, 0);

    // R5: hold until accepted
    wrLvl(0, 8); wrLvl(1, 8);
    pending = 16'h000f; accMode = 0;
    tick(); first = lastObs;
    pending = 16'h0008;
    repeat (3) tick();
    chk("R5 grant held without accept", 32'(lastObs), 32'(first));
    accMode = 1; tick();
    chk("R5 held grant taken on accept", 32'(lastObs), 32'(first));
    pending = '0;

    // random traffic with level writes during scheduling (R9)
    accMode = 2;
    for (int n = 0; n < 4000; n++) begin
      pending = NQ'($urandom);
      if (!mLocked && $urandom % 64 == 0) numQueues = 5'($urandom % 17);
      if ($urandom % 6 == 0) begin
        cfgWe = 1; cfgQueue = 4'($urandom);
        if ($urandom % 8 == 0) cfgLevel = 4'(10 + $urandom % 6);
        else if (cfgQueue < 3 && $urandom % 2 == 0) cfgLevel = 4'd9;
        else cfgLevel = 4'($urandom % 10);
      end
      tick();
      cfgWe = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule